// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block produces four pulse-width-modulated outputs. It is programmed through a plain word-addressed register port with write and read strobes. There are four time bases. Each has a 16-bit prescale divider and an 8-bit phase counter, so one output period lasts the divider value times 256 clock cycles.

Each channel has a duty value and a select field. The select field chooses which of the four time bases the channel follows. The channel output is high while the selected phase is below the duty value. Each channel also has an output enable and a force-high bypass. Every setting takes effect on the next clock edge. Nothing is held back until a period ends.

Software enables a time base by writing a nonzero divider and setting that time base's counter enable. It then writes the duty and select value for each channel. Last, it sets the channel's output enable, and its bypass bit if a constant high level is wanted.

Top module: `mpwm_top`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: Register words are addressed as follows. Word 0 (byte 0x000) holds the output enables in bits 3:0 and the bypass bits in bits 11:8. Word 1 (byte 0x004) holds the counter enables in bits 3:0. Byte 0x008+4n holds divider n in bits 15:0. Byte 0x018+4n holds the duty of channel n in bits 7:0 and its time-base select in bits 9:8. Bits with no function read zero. A read returns data on `rdata` in the cycle after `rd_en`.
- R3: A channel whose output enable is clear drives its output low, whatever its bypass and duty values are.
- R4: An enabled channel whose bypass bit is set drives its output constantly high, whatever its duty value is.
- R5: With a nonzero divider D and its counter enable set, a time base repeats every D×256 clock cycles. The output is high at the start of each period.
- R6: An enabled channel without bypass is high for D×duty cycles in each period. A duty of 0 gives a constant low output.
- R7: A channel follows the time base named by its select field, not the time base with its own index.
- R8: A time base whose counter enable is clear, or whose divider is 0, holds its phase at zero. An enabled channel with a nonzero duty that follows it therefore stays high.
- R9: A new duty or divider value applies from the next clock edge. The period already running is not completed with the old settings, and a smaller divider cannot stall the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pwm_o | output | 4 | Registered PWM outputs, one per channel |

## Verification
The bench sweeps three dividers against duty values that include 0, 1 and 255. It counts high cycles over whole periods. An off-by-one in the prescaler or in the compare would give a wrong count for every duty. The bench times the spacing between rising edges, which catches a phase counter that wraps early or a tick every D+1 cycles.

It routes a channel to a time base other than its own. An ignored select field would then produce a constant high or a wrong high time. It also toggles the bypass and the output enable against each other.

It changes the duty and the divider in the middle of a period. A design that shadows the update until the period ends, or whose prescaler compares only for equality and stalls after the divider shrinks, would show the old high time in the window that follows.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
   // word indices inside the register window (byte address >> 2)
   localparam int unsigned WORD_CTRL = 0;
   localparam int unsigned WORD_CNT  = 1;
   localparam int unsigned WORD_DIV  = 2;
   // bit position of the first bypass flag in the control word
   localparam int unsigned BYP_LSB   = 8;
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
   import mpwm_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [AW-1:0]                 addr,
   input  logic [DW-1:0]                 wdata,
   output logic [DW-1:0]                 rdata,
   output logic [NCH-1:0]                out_en,
   output logic [NCH-1:0]                bypass,
   output logic [NCH-1:0]                cnt_en,
   output logic [NCH-1:0][DIV_W-1:0]     div,
   output logic [NCH-1:0][DUTY_W-1:0]    duty,
   output logic [NCH-1:0][SEL_W-1:0]     sel
);
   localparam int unsigned WORD_DUTY = WORD_DIV + NCH;

   int unsigned word_idx;
   logic [DW-1:0] rd_d;
   logic unused_bits;

   assign word_idx    = 32'(addr[AW-1:2]);
   assign unused_bits = ^{addr[1:0], wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en <= '0;
         bypass <= '0;
         cnt_en <= '0;
         div    <= '0;
         duty   <= '0;
         sel    <= '0;
      end else if (wr_en) begin
         if (word_idx == WORD_CTRL) begin
            out_en <= wdata[NCH-1:0];
            bypass <= wdata[BYP_LSB +: NCH];
         end
         if (word_idx == WORD_CNT) cnt_en <= wdata[NCH-1:0];
         for (int n = 0; n < NCH; n++) begin
            if (word_idx == WORD_DIV + n) div[n] <= wdata[DIV_W-1:0];
            if (word_idx == WORD_DUTY + n) begin
               duty[n] <= wdata[DUTY_W-1:0];
               sel[n]  <= wdata[DUTY_W +: SEL_W];
            end
         end
      end
   end

   always_comb begin
      rd_d = '0;
      if (word_idx == WORD_CTRL) begin
         rd_d[NCH-1:0]         = out_en;
         rd_d[BYP_LSB +: NCH]  = bypass;
      end
      if (word_idx == WORD_CNT) rd_d[NCH-1:0] = cnt_en;
      for (int n = 0; n < NCH; n++) begin
         if (word_idx == WORD_DIV + n) rd_d[DIV_W-1:0] = div[n];
         if (word_idx == WORD_DUTY + n) begin
            rd_d[DUTY_W-1:0]       = duty[n];
            rd_d[DUTY_W +: SEL_W]  = sel[n];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_en)  rdata <= rd_d;
   end
endmodule

// File: rtl/mpwm_tbase.sv
module mpwm_tbase #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned PH_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [DIV_W-1:0] div,
   output logic [PH_W-1:0]  phase
);
   logic [DIV_W-1:0] pre_q;
   logic             run;

   assign run = cnt_en && (div != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         phase <= '0;
      end else if (!run) begin
         pre_q <= '0;
         phase <= '0;
      end else if (pre_q >= div - 1'b1) begin
         // >= so that a shrunken divider ticks at once instead of wrapping
         pre_q <= '0;
         phase <= phase + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan #(
   parameter int unsigned NTB   = 4,
   parameter int unsigned PH_W  = 8,
   parameter int unsigned SEL_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NTB-1:0][PH_W-1:0]   phases,
   input  logic [SEL_W-1:0]           sel,
   input  logic [PH_W-1:0]            duty,
   input  logic                       out_en,
   input  logic                       bypass,
   output logic                       pwm_q
);
   logic [PH_W-1:0] ph_sel;
   logic            pwm_d;

   generate
      if ((1 << SEL_W) == NTB) begin : g_full
         assign ph_sel = phases[sel];
      end else begin : g_guard
         assign ph_sel = (32'(sel) < NTB) ? phases[sel] : '0;
      end
   endgenerate

   always_comb begin
      if (!out_en)     pwm_d = 1'b0;
      else if (bypass) pwm_d = 1'b1;
      else             pwm_d = (ph_sel < duty);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= pwm_d;
   end
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
   import mpwm_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   output logic [NCH-1:0] pwm_o
);
   localparam int unsigned SEL_W = $clog2(NCH);
   localparam int unsigned NWORD = WORD_DIV + 2 * NCH;

   generate
      if (NCH < 2 || NCH > 8) begin : g_bad_nch
         $fatal(1, "NCH must lie in 2..8");
      end
      if (DW < BYP_LSB + NCH || DW < DIV_W || DW < DUTY_W + SEL_W) begin : g_bad_dw
         $fatal(1, "DW too narrow for the register fields");
      end
      if ((NWORD * 4) > (1 << AW)) begin : g_bad_aw
         $fatal(1, "AW too small for the register window");
      end
   endgenerate

   logic [NCH-1:0]              out_en_q, bypass_q, cnt_en_q;
   logic [NCH-1:0][DIV_W-1:0]   div_q;
   logic [NCH-1:0][DUTY_W-1:0]  duty_q;
   logic [NCH-1:0][SEL_W-1:0]   sel_q;
   logic [NCH-1:0][DUTY_W-1:0]  tb_phase;

   mpwm_regs #(
      .NCH(NCH), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .SEL_W(SEL_W), .AW(AW), .DW(DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .out_en(out_en_q), .bypass(bypass_q), .cnt_en(cnt_en_q),
      .div(div_q), .duty(duty_q), .sel(sel_q)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_tb
      mpwm_tbase #(.DIV_W(DIV_W), .PH_W(DUTY_W)) u_tb (
         .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en_q[k]),
         .div(div_q[k]), .phase(tb_phase[k])
      );
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      mpwm_chan #(.NTB(NCH), .PH_W(DUTY_W), .SEL_W(SEL_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .phases(tb_phase), .sel(sel_q[n]),
         .duty(duty_q[n]), .out_en(out_en_q[n]), .bypass(bypass_q[n]),
         .pwm_q(pwm_o[n])
      );
   end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rd_en,
   input logic [AW-1:0]               addr,
   input logic [DW-1:0]               rdata,
   input logic [NCH-1:0]              out_en,
   input logic [NCH-1:0]              bypass,
   input logic [NCH-1:0]              cnt_en,
   input logic [NCH-1:0][DIV_W-1:0]   div,
   input logic [NCH-1:0][DUTY_W-1:0]  duty,
   input logic [NCH-1:0][DUTY_W-1:0]  phase,
   input logic [NCH-1:0]              pwm_o
);
   localparam int unsigned DUTY_FIRST = 2 + NCH;
   localparam int unsigned DUTY_LAST  = 1 + 2 * NCH;

   logic rd_duty;
   assign rd_duty = rd_en && (32'(addr[AW-1:2]) >= DUTY_FIRST) && (32'(addr[AW-1:2]) <= DUTY_LAST);

   AST_DUTY_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_duty |=> (rdata[DW-1:DUTY_W+SEL_W] == '0)); // R2

   for (genvar n = 0; n < NCH; n++) begin : g_a
      AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en[n] |=> !pwm_o[n]); // R3
      AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en[n] && bypass[n]) |=> pwm_o[n]); // R4
      AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en[n] && !bypass[n] && duty[n] == '0) |=> !pwm_o[n]); // R6
      AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (!cnt_en[n] || div[n] == '0) |=> (phase[n] == '0)); // R8
      AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_en[n] && div[n] != '0) |=>
            (phase[n] == $past(phase[n]) || phase[n] == DUTY_W'($past(phase[n]) + 1'b1))); // R5
   end
endmodule

bind mpwm_top mpwm_chk #(
   .NCH(NCH), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .SEL_W(SEL_W), .AW(AW), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
   .out_en(out_en_q), .bypass(bypass_q), .cnt_en(cnt_en_q),
   .div(div_q), .duty(duty_q), .phase(tb_phase), .pwm_o(pwm_o)
);

// File: tb/mpwm_top_tb.sv
module mpwm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  pwm_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mpwm_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04;
   function automatic logic [7:0] a_div(int n);  return 8'(8 + 4 * n);  endfunction
   function automatic logic [7:0] a_duty(int n); return 8'(24 + 4 * n); endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic count_high(input int ch, input int cyc, output int h);
      h = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         h += int'(pwm_o[ch]);
      end
   endtask

   // high time and full period measured from one rising edge to the next
   task automatic measure(input int ch, output int hi, output int per);
      while (pwm_o[ch]) @(negedge clk);
      while (!pwm_o[ch]) @(negedge clk);
      hi = 0; per = 0;
      while (pwm_o[ch]) begin @(negedge clk); hi++; per++; end
      while (!pwm_o[ch]) begin @(negedge clk); per++; end
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int h, hi, per;
      int duties[6] = '{0, 1, 2, 100, 128, 255};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check(pwm_o == 4'h0, "R1 outputs low", pwm_o, 0);
      for (int w = 0; w < 10; w++) begin
         rd(8'(4 * w), d);
         check(d == 32'h0, "R1 register reset", d, 0);
      end

      // R2: masks and decoding
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check(d == 32'h0F0F, "R2 ctrl mask", d, 32'h0F0F);
      wr(A_CTRL, 32'h0);
      wr(A_CNT, 32'hFFFF_FFFF);  rd(A_CNT, d);  check(d == 32'h000F, "R2 cnt mask", d, 32'hF);
      wr(A_CNT, 32'h0);
      wr(a_div(0), 32'hFFFF_FFFF); rd(a_div(0), d); check(d == 32'hFFFF, "R2 div mask", d, 32'hFFFF);
      wr(a_duty(3), 32'hFFFF_FFFF); rd(a_duty(3), d); check(d == 32'h03FF, "R2 duty mask", d, 32'h3FF);
      wr(a_div(0), 32'h0); wr(a_duty(3), 32'h0);
      wr(a_div(1), 32'h1234); rd(a_div(0), d); check(d == 32'h0, "R2 div decode", d, 0);
      rd(a_div(1), d); check(d == 32'h1234, "R2 div readback", d, 32'h1234);
      wr(a_div(1), 32'h0);

      // R6: sweep dividers and duties on channel 0 / time base 0
      wr(A_CNT, 32'h1);
      wr(A_CTRL, 32'h1);
      for (int dv = 1; dv <= 3; dv++) begin
         wr(a_div(0), 32'(dv));
         for (int k = 0; k < 6; k++) begin
            wr(a_duty(0), 32'(duties[k]));
            repeat (256 * dv + 4) @(negedge clk);
            count_high(0, 256 * dv, h);
            check(h == dv * duties[k], "R6 high count", h, dv * duties[k]);
         end
      end

      // R5: period length from rising-edge spacing
      for (int dv = 2; dv <= 3; dv++) begin
         wr(a_div(0), 32'(dv));
         wr(a_duty(0), 32'd10);
         repeat (256 * dv + 4) @(negedge clk);
         measure(0, hi, per);
         check(per == 256 * dv, "R5 period", per, 256 * dv);
         check(hi == 10 * dv, "R5 high at period start", hi, 10 * dv);
      end

      // R7: channel 1 follows time base 2, channel 3 follows time base 0
      wr(a_div(0), 32'd1);
      wr(a_div(2), 32'd3);
      wr(A_CNT, 32'h5);
      wr(a_duty(1), (32'd2 << 8) | 32'd50);
      wr(a_duty(3), (32'd0 << 8) | 32'd50);
      wr(A_CTRL, 32'hB);
      repeat (800) @(negedge clk);
      count_high(1, 768, h); check(h == 150, "R7 select time base 2", h, 150);
      count_high(3, 256, h); check(h == 50, "R7 select time base 0", h, 50);

      // R4: bypass on channel 1 with duty 0
      wr(a_duty(1), (32'd2 << 8));
      wr(A_CTRL, 32'h020B);
      count_high(1, 768, h); check(h == 768, "R4 bypass high", h, 768);

      // R3: bypass kept, enable cleared; channel 3 disabled with nonzero duty
      wr(A_CTRL, 32'h0201);
      count_high(1, 600, h); check(h == 0, "R3 disabled with bypass", h, 0);
      count_high(3, 300, h); check(h == 0, "R3 disabled with duty", h, 0);

      // R8: stopped time base holds phase at zero
      wr(a_div(0), 32'd2);
      wr(a_duty(0), 32'd100);
      wr(A_CNT, 32'h4);
      repeat (3) @(negedge clk);
      count_high(0, 600, h); check(h == 600, "R8 counter enable clear", h, 600);
      wr(a_div(0), 32'd0);
      wr(A_CNT, 32'h5);
      repeat (3) @(negedge clk);
      count_high(0, 600, h); check(h == 600, "R8 divider zero", h, 600);

      // R9: immediate duty then divider update mid-period
      wr(a_div(0), 32'd2);
      wr(a_duty(0), 32'd40);
      repeat (700) @(negedge clk);
      wr(a_duty(0), 32'd200);
      @(negedge clk);
      count_high(0, 512, h); check(h == 400, "R9 duty immediate", h, 400);
      repeat (100) @(negedge clk);
      wr(a_div(0), 32'd1);
      repeat (2) @(negedge clk);
      count_high(0, 256, h); check(h == 200, "R9 divider immediate", h, 200);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule